// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control sequencer for a 32-bit processor that runs each instruction over several clock cycles. One memory port, one ALU and a set of internal holding registers are shared from step to step. Every instruction passes through a common fetch step and a common decode step. The controller then branches into a short path for the instruction's class: load, store, register-to-register arithmetic, conditional branch on equality, or unconditional jump. When the path is done, control returns to fetch.

The controller reads the 6-bit opcode field from the processor's instruction register. It keeps a 4-bit state number. In every cycle it drives the datapath's write enables, memory strobes and multiplexer selects as a pure function of the state it is in. The next state is computed from the current state and the opcode. All outputs come from registers that load together with the state, so the outputs always match `state_o` and never glitch. The datapath and the memory are outside this block.

Top module: `mcyc_ctl`

## Requirements
- R1: A synchronous active-high reset puts the controller in state 0. In the first cycle after reset the outputs hold the state-0 values listed in R2.
- R2: State 0 (fetch) drives `pc_wr`=1, `mem_rd`=1, `ir_ld`=1, `mem_addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_mode`=00 and `pc_src`=00. The next state is always 1.
- R3: State 1 (decode) drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_mode`=00. It dispatches on the opcode as follows: 100011 (load) and 101011 (store) go to state 2, 000000 (register op) goes to state 6, 000100 (branch) goes to state 8, and 000010 (jump) goes to state 9.
- R4: A load visits states 0,1,2,3,4 and then returns to 0, taking 5 cycles. State 2 drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_mode`=00. State 3 drives `mem_rd`=1 and `mem_addr_sel`=1. State 4 drives `rf_wr`=1, `wb_from_mem`=1 and `wb_dst_sel`=0.
- R5: A store visits states 0,1,2,5 and then returns to 0, taking 4 cycles. State 5 drives `mem_wr`=1 and `mem_addr_sel`=1.
- R6: A register op visits states 0,1,6,7 and then returns to 0, taking 4 cycles. State 6 drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10. State 7 drives `rf_wr`=1, `wb_dst_sel`=1 and `wb_from_mem`=0.
- R7: A branch visits states 0,1,8 and then returns to 0, taking 3 cycles. State 8 drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_wr_cond`=1 and `pc_src`=01.
- R8: A jump visits states 0,1,9 and then returns to 0, taking 3 cycles. State 9 drives `pc_wr`=1 and `pc_src`=10.
- R9: Any other opcode seen in state 1 sends the controller back to state 0. No write enable (`pc_wr`, `pc_wr_cond`, `mem_wr`, `rf_wr`, `ir_ld`) is asserted in that state 1 cycle.
- R10: Every output not named for a state is 0 in that state. `mem_rd` and `mem_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| state_o | output | 4 | Current state number |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when the ALU reports equality |
| mem_addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data source: 0 ALU result, 1 memory data register |
| rf_wr | output | 1 | Register file write enable |
| pc_src | output | 2 | Next PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 use function field |
| alu_a_sel | output | 1 | ALU A operand: 0 program counter, 1 A register |
| alu_b_sel | output | 2 | ALU B operand: 00 B register, 01 constant 4, 10 extended offset, 11 shifted offset |
| wb_dst_sel | output | 1 | Destination register field: 0 bits 20-16, 1 bits 15-11 |

## Verification
The hardest paths to reach are the fallback paths. One is an unrecognised opcode that must leave decode without asserting any write. The other is the store/load split at state 2, which is taken only when the opcode held over two cycles names a memory access. To reach them, the bench sweeps all 64 opcode values. For each value it resets the controller, holds the opcode steady and follows the state sequence cycle by cycle until the controller returns to fetch. At every step it compares the state number, the full output set and the path length against a model derived from the requirements.

// File: rtl/mcyc_ctl_pkg.sv
package mcyc_ctl_pkg;
  localparam int STATE_W = 4;
  localparam int OP_W    = 6;
  localparam int SEL_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDMEM  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STMEM  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } state_e;

  typedef struct packed {
    logic             pc_wr;
    logic             pc_wr_cond;
    logic             mem_addr_sel;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_ld;
    logic             wb_from_mem;
    logic             rf_wr;
    logic [SEL_W-1:0] pc_src;
    logic [SEL_W-1:0] alu_mode;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic             wb_dst_sel;
  } ctl_t;

  localparam logic [SEL_W-1:0] PCS_ALU    = 2'b00;
  localparam logic [SEL_W-1:0] PCS_ALUREG = 2'b01;
  localparam logic [SEL_W-1:0] PCS_JUMP   = 2'b10;
  localparam logic [SEL_W-1:0] AM_ADD     = 2'b00;
  localparam logic [SEL_W-1:0] AM_SUB     = 2'b01;
  localparam logic [SEL_W-1:0] AM_FUNC    = 2'b10;
  localparam logic [SEL_W-1:0] BS_REG     = 2'b00;
  localparam logic [SEL_W-1:0] BS_FOUR    = 2'b01;
  localparam logic [SEL_W-1:0] BS_EXT     = 2'b10;
  localparam logic [SEL_W-1:0] BS_SHEXT   = 2'b11;
endpackage

// File: rtl/mcyc_ctl_next.sv
module mcyc_ctl_next
  import mcyc_ctl_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_REG   = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_JMP   = 6'b000010
) (
  input  state_e          cur,
  input  logic [OP_W-1:0] opcode,
  output state_e          nxt
);
  logic is_mem;
  assign is_mem = (opcode == OP_LOAD) || (opcode == OP_STORE);

  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (is_mem)                nxt = ST_ADDR;
        else if (opcode == OP_REG) nxt = ST_EXEC;
        else if (opcode == OP_BEQ) nxt = ST_BRANCH;
        else if (opcode == OP_JMP) nxt = ST_JUMP;
        else                       nxt = ST_FETCH;
      end
      ST_ADDR:   nxt = (opcode == OP_STORE) ? ST_STMEM : ST_LDMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_ctl_decode.sv
module mcyc_ctl_decode
  import mcyc_ctl_pkg::*;
(
  input  state_e st,
  output ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    case (st)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_ld     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.pc_src    = PCS_ALU;
        ctl.alu_b_sel = BS_FOUR;
        ctl.alu_mode  = AM_ADD;
      end
      ST_DECODE: begin
        ctl.alu_b_sel = BS_SHEXT;
        ctl.alu_mode  = AM_ADD;
      end
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BS_EXT;
        ctl.alu_mode  = AM_ADD;
      end
      ST_LDMEM: begin
        ctl.mem_rd       = 1'b1;
        ctl.mem_addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_wr       = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      ST_STMEM: begin
        ctl.mem_wr       = 1'b1;
        ctl.mem_addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BS_REG;
        ctl.alu_mode  = AM_FUNC;
      end
      ST_RWB: begin
        ctl.rf_wr      = 1'b1;
        ctl.wb_dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_b_sel  = BS_REG;
        ctl.alu_mode   = AM_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = PCS_ALUREG;
      end
      ST_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_JUMP;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_ctl_regs.sv
module mcyc_ctl_regs
  import mcyc_ctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_e nxt,
  input  ctl_t   ctl_d,
  output state_e state_q,
  output ctl_t   ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= nxt;
    ctl_q <= ctl_d;
  end
endmodule

// File: rtl/mcyc_ctl.sv
module mcyc_ctl
  import mcyc_ctl_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_REG   = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_JMP   = 6'b000010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  output logic [STATE_W-1:0] state_o,
  output logic               pc_wr,
  output logic               pc_wr_cond,
  output logic               mem_addr_sel,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               ir_ld,
  output logic               wb_from_mem,
  output logic               rf_wr,
  output logic [SEL_W-1:0]   pc_src,
  output logic [SEL_W-1:0]   alu_mode,
  output logic               alu_a_sel,
  output logic [SEL_W-1:0]   alu_b_sel,
  output logic               wb_dst_sel
);
  state_e state_q, nxt, dec_sel;
  ctl_t   ctl_d, ctl_q;

  mcyc_ctl_next #(
    .OP_REG(OP_REG), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_BEQ(OP_BEQ), .OP_JMP(OP_JMP)
  ) u_next (
    .cur(state_q), .opcode(opcode), .nxt(nxt)
  );

  // Outputs are decoded from the state about to be entered and loaded
  // alongside it, so they line up with state_q without a decode delay.
  assign dec_sel = rst ? ST_FETCH : nxt;

  mcyc_ctl_decode u_dec (.st(dec_sel), .ctl(ctl_d));

  mcyc_ctl_regs u_regs (
    .clk(clk), .rst(rst), .nxt(nxt), .ctl_d(ctl_d),
    .state_q(state_q), .ctl_q(ctl_q)
  );

  assign state_o      = state_q;
  assign pc_wr        = ctl_q.pc_wr;
  assign pc_wr_cond   = ctl_q.pc_wr_cond;
  assign mem_addr_sel = ctl_q.mem_addr_sel;
  assign mem_rd       = ctl_q.mem_rd;
  assign mem_wr       = ctl_q.mem_wr;
  assign ir_ld        = ctl_q.ir_ld;
  assign wb_from_mem  = ctl_q.wb_from_mem;
  assign rf_wr        = ctl_q.rf_wr;
  assign pc_src       = ctl_q.pc_src;
  assign alu_mode     = ctl_q.alu_mode;
  assign alu_a_sel    = ctl_q.alu_a_sel;
  assign alu_b_sel    = ctl_q.alu_b_sel;
  assign wb_dst_sel   = ctl_q.wb_dst_sel;
endmodule

// File: rtl/mcyc_ctl_chk.sv
module mcyc_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] state,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       mem_addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       rf_wr,
  input logic       ir_ld,
  input logic [1:0] pc_src
);
  a_r1_reset_fetch: assert property (@(posedge clk) rst |=> state == 4'd0);

  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    state == 4'd0 |=> state == 4'd1);

  a_r3_decode_targets: assert property (@(posedge clk) disable iff (rst)
    state == 4'd1 |=> (state == 4'd0 || state == 4'd2 || state == 4'd6 ||
                       state == 4'd8 || state == 4'd9));

  a_r4_load_mem_then_wb: assert property (@(posedge clk) disable iff (rst)
    state == 4'd3 |=> (state == 4'd4 && rf_wr));

  a_r5_store_uses_alu_addr: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_addr_sel);

  a_r6_rwb_returns: assert property (@(posedge clk) disable iff (rst)
    state == 4'd7 |=> state == 4'd0);

  a_r7_cond_write_src: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> (pc_src == 2'b01 && !pc_wr));

  a_r9_decode_no_write: assert property (@(posedge clk) disable iff (rst)
    state == 4'd1 |-> !(pc_wr || pc_wr_cond || mem_wr || rf_wr || ir_ld));

  a_r10_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

bind mcyc_ctl mcyc_ctl_chk u_chk (
  .clk(clk), .rst(rst), .state(state_o),
  .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .rf_wr(rf_wr), .ir_ld(ir_ld),
  .pc_src(pc_src)
);

// File: tb/mcyc_ctl_tb.sv
module mcyc_ctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] state_o;
  logic pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_ld;
  logic wb_from_mem, rf_wr, alu_a_sel, wb_dst_sel;
  logic [1:0] pc_src, alu_mode, alu_b_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mcyc_ctl u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld),
    .wb_from_mem(wb_from_mem), .rf_wr(rf_wr), .pc_src(pc_src),
    .alu_mode(alu_mode), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .wb_dst_sel(wb_dst_sel)
  );

  // {pc_wr,pc_wr_cond,mem_addr_sel,mem_rd,mem_wr,ir_ld,wb_from_mem,rf_wr,
  //  pc_src[1:0],alu_mode[1:0],alu_a_sel,alu_b_sel[1:0],wb_dst_sel}
  function automatic logic [15:0] exp_ctl(input int s);
    case (s)
      0: return {8'b1001_0100, 2'b00, 2'b00, 1'b0, 2'b01, 1'b0}; // R2
      1: return {8'b0000_0000, 2'b00, 2'b00, 1'b0, 2'b11, 1'b0}; // R3
      2: return {8'b0000_0000, 2'b00, 2'b00, 1'b1, 2'b10, 1'b0}; // R4
      3: return {8'b0011_0000, 2'b00, 2'b00, 1'b0, 2'b00, 1'b0}; // R4
      4: return {8'b0000_0011, 2'b00, 2'b00, 1'b0, 2'b00, 1'b0}; // R4
      5: return {8'b0010_1000, 2'b00, 2'b00, 1'b0, 2'b00, 1'b0}; // R5
      6: return {8'b0000_0000, 2'b00, 2'b10, 1'b1, 2'b00, 1'b0}; // R6
      7: return {8'b0000_0001, 2'b00, 2'b00, 1'b0, 2'b00, 1'b1}; // R6
      8: return {8'b0100_0000, 2'b01, 2'b01, 1'b1, 2'b00, 1'b0}; // R7
      9: return {8'b1000_0000, 2'b10, 2'b00, 1'b0, 2'b00, 1'b0}; // R8
      default: return 16'h0;
    endcase
  endfunction

  function automatic int exp_next(input int s, input logic [5:0] op);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000000) return 6;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        return 0; // R9
      end
      2: return (op == 6'b101011) ? 5 : 3;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(input logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b101011, 6'b000000: return 4;
      6'b000100, 6'b000010: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string req_of(input int s, input logic [5:0] op);
    case (s)
      0: return "R2";
      1: return (exp_len(op) == 2) ? "R9" : "R3";
      2, 3, 4: return "R4";
      5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] act_ctl();
    return {pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_ld,
            wb_from_mem, rf_wr, pc_src, alu_mode, alu_a_sel, alu_b_sel,
            wb_dst_sel};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%b actual=%h expected=%h", req, opcode, act, exp);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int op = 0; op < 64; op++) begin
      int s;
      int len;
      rst = 1'b1;
      opcode = op[5:0];
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state and fetch outputs
      check("R1", int'(state_o), 0);
      check("R1", int'(act_ctl()), int'(exp_ctl(0)));
      s = 0;
      len = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        len++;
        s = exp_next(s, op[5:0]);
        check(req_of(s, op[5:0]), int'(state_o), s);
        check(req_of(s, op[5:0]), int'(act_ctl()), int'(exp_ctl(s))); // R10
        if (mem_rd && mem_wr) check("R10", 1, 0);
        if (s == 0) break;
      end
      // R4 R5 R6 R7 R8 R9 path length in cycles
      check((exp_len(op[5:0]) == 2) ? "R9" : "R4", len, exp_len(op[5:0]));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule